// File: doc/BRIEF.md
# Translation Cache with Hotness Counters

This block helps a dynamic binary translator decide, on every guest branch, whether translated host code exists for the target. A lookup of the guest target address returns the host address of the translated block on a hit. On a miss the caller emulates the block. The block counts how often each missed target runs. Once the count reaches a programmable threshold, it raises a single translate request for that target. The threshold is best set near the translation cost divided by the cost of one emulated run, which keeps total cost within about twice the optimum.

Software installs a finished translation through the install port. A guest store is snooped on the page-write port. Every translation and every run counter whose guest address lies in the written 4 KiB page is discarded, so self-modifying code is never served a stale translation. The cache holds 32 entries, organised as 8 sets of 4 ways with least-recently-used replacement. Counters live in a separate 64-slot direct-mapped table of 8-bit tagged counters.

Top module: `tc_xlate_cache`

## Requirements
- R1: While rst_ni is low and after its release, res_valid_o, res_hit_o, res_host_o and xlate_req_o are zero, no entry hits and every counter is zero.
- R2: A lookup presented with lk_valid_i in cycle t produces res_valid_o in cycle t+1. On a hit, res_hit_o is 1 and res_host_o carries the installed host address.
- R3: A lookup miss gives res_valid_o=1, res_hit_o=0 and res_host_o=0, and adds one to the run counter of that guest address.
- R4: xlate_req_o pulses together with the miss result that brings the counter to the threshold, and xlate_addr_o carries the guest address. Later misses to the same address hold the counter and raise no further request.
- R5: threshold_i is sampled on every miss. A threshold of 1 requests on the first miss, and a threshold of 0 never requests.
- R6: The counter slot is selected by guest address bits [7:2] and tagged with the full address. A miss to a different address in an occupied slot replaces the slot and restarts the count at 1.
- R7: An install is visible to a lookup in the following cycle. An install to a guest address already present replaces that entry's host address.
- R8: The set is selected by guest address bits [4:2]. A free way is filled first. When the set is full, the least recently installed-or-hit way is replaced.
- R9: A page write invalidates every entry whose guest address shares bits [31:12] with snoop_addr_i, and clears the matching counters. Entries in other pages are kept.
- R10: An install presented in the same cycle as a page write is discarded.
- R11: A lookup hit leaves the run counter of that address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| threshold_i | input | 8 | Run count that triggers a translate request |
| lk_valid_i | input | 1 | Lookup strobe |
| lk_addr_i | input | 32 | Guest branch target to look up |
| ins_valid_i | input | 1 | Install strobe |
| ins_guest_i | input | 32 | Guest address of the translation |
| ins_host_i | input | 32 | Host address of the translation |
| snoop_valid_i | input | 1 | Guest page write seen |
| snoop_addr_i | input | 32 | Guest address written |
| res_valid_o | output | 1 | Lookup result valid |
| res_hit_o | output | 1 | Lookup hit |
| res_host_o | output | 32 | Host address on hit, zero on miss |
| xlate_req_o | output | 1 | Translate request pulse |
| xlate_addr_o | output | 32 | Guest address to translate |

## Verification
The bench fills one set and then refreshes ways in a chosen order before a fifth install. A design with wrong recency tracking would evict a live translation instead of the stale one, which would show up as a miss. It also runs hits between misses on an evicted block: a design that counted hits would request early. It flushes a page holding a partly counted block, and one that kept the counter would request after too few misses. Aliased counter slots, thresholds of 0 and 1, repeated misses after a request, and an install colliding with a page write are each checked. A design that ignored the tag, compared against the threshold off by one, fired more than once, or let the install through would produce a wrong request or a wrong hit.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    INS_MATCH,
    INS_FREE,
    INS_VICTIM
  } ins_kind_e;
endpackage

// File: rtl/tc_lru.sv
module tc_lru #(
  parameter int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] lru_way_o
);
  // age 0 = most recent, WAYS-1 = victim; ages stay a permutation
  logic [WAY_W-1:0] age_q [WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WAYS; i++) age_q[i] <= WAY_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < WAYS; i++) begin
        if (WAY_W'(i) == touch_way_i) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_way_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_way_o = '0;
    for (int i = 0; i < WAYS; i++)
      if (age_q[i] == WAY_W'(WAYS - 1)) lru_way_o = WAY_W'(i);
  end
endmodule

// File: rtl/tc_counters.sv
module tc_counters #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 8,
  parameter int CTR_ENTRIES = 64,
  parameter int ALIGN       = 2,
  parameter int PAGE_BITS   = 12,
  localparam int IDX_W      = $clog2(CTR_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  threshold_i,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_addr_o
);
  logic              vld_q [CTR_ENTRIES];
  logic [ADDR_W-1:0] tag_q [CTR_ENTRIES];
  logic [CNT_W-1:0]  cnt_q [CTR_ENTRIES];

  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cur, nxt;
  logic [CNT_W:0]   inc;
  logic             fire;

  assign idx = addr_i[ALIGN +: IDX_W];

  always_comb begin
    cur  = (vld_q[idx] && tag_q[idx] == addr_i) ? cnt_q[idx] : '0;
    inc  = {1'b0, cur} + 1'b1;
    fire = (cur < threshold_i) && (inc == {1'b0, threshold_i});
    nxt  = (cur < threshold_i) ? inc[CNT_W-1:0] : cur;  // held once reached
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CTR_ENTRIES; i++) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
        cnt_q[i] <= '0;
      end
      req_o      <= 1'b0;
      req_addr_o <= '0;
    end else begin
      req_o      <= miss_i && fire;
      req_addr_o <= (miss_i && fire) ? addr_i : '0;
      if (miss_i) begin
        vld_q[idx] <= 1'b1;
        tag_q[idx] <= addr_i;
        cnt_q[idx] <= nxt;
      end
      if (flush_i) begin
        for (int i = 0; i < CTR_ENTRIES; i++) begin
          if (miss_i && IDX_W'(i) == idx) begin
            if (addr_i[ADDR_W-1:PAGE_BITS] == flush_addr_i[ADDR_W-1:PAGE_BITS]) begin
              vld_q[i] <= 1'b0;
              cnt_q[i] <= '0;
            end
          end else if (vld_q[i] &&
                       tag_q[i][ADDR_W-1:PAGE_BITS] == flush_addr_i[ADDR_W-1:PAGE_BITS]) begin
            vld_q[i] <= 1'b0;
            cnt_q[i] <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tc_xlate_cache.sv
module tc_xlate_cache #(
  parameter int ADDR_W      = 32,
  parameter int HOST_W      = 32,
  parameter int SETS        = 8,
  parameter int WAYS        = 4,
  parameter int CTR_ENTRIES = 64,
  parameter int CNT_W       = 8,
  parameter int ALIGN       = 2,
  parameter int PAGE_BITS   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  threshold_i,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic              ins_valid_i,
  input  logic [ADDR_W-1:0] ins_guest_i,
  input  logic [HOST_W-1:0] ins_host_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic              res_valid_o,
  output logic              res_hit_o,
  output logic [HOST_W-1:0] res_host_o,
  output logic              xlate_req_o,
  output logic [ADDR_W-1:0] xlate_addr_o
);
  import tc_pkg::*;

  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic              vld_q  [SETS][WAYS];
  logic [ADDR_W-1:0] gtag_q [SETS][WAYS];
  logic [HOST_W-1:0] host_q [SETS][WAYS];

  // lookup
  logic [SET_W-1:0]  lk_set;
  logic [WAYS-1:0]   lk_hit_vec;
  logic              lk_hit;
  logic [WAY_W-1:0]  lk_way;
  logic [HOST_W-1:0] lk_host;

  assign lk_set = lk_addr_i[ALIGN +: SET_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_lk_cmp
    assign lk_hit_vec[w] = vld_q[lk_set][w] && gtag_q[lk_set][w] == lk_addr_i;
  end

  always_comb begin
    lk_way  = '0;
    lk_host = '0;
    for (int w = 0; w < WAYS; w++)
      if (lk_hit_vec[w]) begin
        lk_way  = WAY_W'(w);
        lk_host = host_q[lk_set][w];
      end
  end
  assign lk_hit = |lk_hit_vec;

  // install
  logic [SET_W-1:0] ins_set;
  logic             ins_acc;
  logic [WAY_W-1:0] ins_way;
  logic [WAY_W-1:0] lru_way [SETS];
  ins_kind_e        ins_kind;

  assign ins_set = ins_guest_i[ALIGN +: SET_W];
  assign ins_acc = ins_valid_i && !snoop_valid_i;  // page write wins

  always_comb begin
    ins_kind = INS_VICTIM;
    ins_way  = lru_way[ins_set];
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_q[ins_set][w] && ins_kind != INS_MATCH) begin
        ins_kind = INS_FREE;
        ins_way  = WAY_W'(w);
      end
    for (int w = 0; w < WAYS; w++)
      if (vld_q[ins_set][w] && gtag_q[ins_set][w] == ins_guest_i) begin
        ins_kind = INS_MATCH;
        ins_way  = WAY_W'(w);
      end
  end

  // recency: install touch takes the cycle over a lookup hit
  for (genvar s = 0; s < SETS; s++) begin : g_lru
    logic             touch;
    logic [WAY_W-1:0] touch_way;
    assign touch = ins_acc ? (ins_set == SET_W'(s))
                           : (lk_valid_i && lk_hit && lk_set == SET_W'(s));
    assign touch_way = ins_acc ? ins_way : lk_way;
    tc_lru #(.WAYS(WAYS)) u_lru (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .touch_i    (touch),
      .touch_way_i(touch_way),
      .lru_way_o  (lru_way[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w]  <= 1'b0;
          gtag_q[s][w] <= '0;
          host_q[s][w] <= '0;
        end
    end else begin
      if (ins_acc) begin
        vld_q[ins_set][ins_way]  <= 1'b1;
        gtag_q[ins_set][ins_way] <= ins_guest_i;
        host_q[ins_set][ins_way] <= ins_host_i;
      end
      if (snoop_valid_i) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            if (gtag_q[s][w][ADDR_W-1:PAGE_BITS] == snoop_addr_i[ADDR_W-1:PAGE_BITS])
              vld_q[s][w] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_hit_o   <= 1'b0;
      res_host_o  <= '0;
    end else begin
      res_valid_o <= lk_valid_i;
      res_hit_o   <= lk_valid_i && lk_hit;
      res_host_o  <= (lk_valid_i && lk_hit) ? lk_host : '0;
    end
  end

  tc_counters #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .CTR_ENTRIES(CTR_ENTRIES),
    .ALIGN      (ALIGN),
    .PAGE_BITS  (PAGE_BITS)
  ) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .miss_i      (lk_valid_i && !lk_hit),
    .addr_i      (lk_addr_i),
    .threshold_i (threshold_i),
    .flush_i     (snoop_valid_i),
    .flush_addr_i(snoop_addr_i),
    .req_o       (xlate_req_o),
    .req_addr_o  (xlate_addr_o)
  );
endmodule

// File: rtl/tc_xlate_cache_chk.sv
module tc_xlate_cache_chk #(
  parameter int ADDR_W    = 32,
  parameter int HOST_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lk_valid_i,
  input logic [ADDR_W-1:0] lk_addr_i,
  input logic              ins_valid_i,
  input logic [ADDR_W-1:0] ins_guest_i,
  input logic [HOST_W-1:0] ins_host_i,
  input logic              snoop_valid_i,
  input logic [ADDR_W-1:0] snoop_addr_i,
  input logic              res_valid_o,
  input logic              res_hit_o,
  input logic [HOST_W-1:0] res_host_o,
  input logic              xlate_req_o,
  input logic [ADDR_W-1:0] xlate_addr_o
);
  p_result_timing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o == $past(lk_valid_i));

  p_hit_needs_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_hit_o |-> res_valid_o);

  p_miss_host_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_hit_o) |-> res_host_o == '0);

  p_req_on_miss_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xlate_req_o |-> (res_valid_o && !res_hit_o && xlate_addr_o == $past(lk_addr_i)));

  p_req_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xlate_req_o && !$past(snoop_valid_i)) |=>
      !(xlate_req_o && xlate_addr_o == $past(xlate_addr_o)));

  p_install_visible_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ins_valid_i && !snoop_valid_i) && lk_valid_i && lk_addr_i == $past(ins_guest_i))
      |=> (res_hit_o && res_host_o == $past(ins_host_i, 2)));

  p_flush_misses_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(snoop_valid_i) && lk_valid_i &&
     lk_addr_i[ADDR_W-1:PAGE_BITS] == $past(snoop_addr_i[ADDR_W-1:PAGE_BITS]))
      |=> !res_hit_o);
endmodule

bind tc_xlate_cache tc_xlate_cache_chk #(
  .ADDR_W   (ADDR_W),
  .HOST_W   (HOST_W),
  .PAGE_BITS(PAGE_BITS)
) u_chk (.*);

// File: tb/tc_xlate_cache_test.sv
`timescale 1ns/1ps
module tc_xlate_cache_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  threshold = 8'd3;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        ins_valid = 1'b0;
  logic [31:0] ins_guest = '0;
  logic [31:0] ins_host = '0;
  logic        snoop_valid = 1'b0;
  logic [31:0] snoop_addr = '0;
  logic        res_valid, res_hit, xlate_req;
  logic [31:0] res_host, xlate_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tc_xlate_cache uut (
    .clk_i(clk), .rst_ni(rst_ni), .threshold_i(threshold),
    .lk_valid_i(lk_valid), .lk_addr_i(lk_addr),
    .ins_valid_i(ins_valid), .ins_guest_i(ins_guest), .ins_host_i(ins_host),
    .snoop_valid_i(snoop_valid), .snoop_addr_i(snoop_addr),
    .res_valid_o(res_valid), .res_hit_o(res_hit), .res_host_o(res_host),
    .xlate_req_o(xlate_req), .xlate_addr_o(xlate_addr)
  );

  typedef struct {
    bit          hit;
    logic [31:0] host;
    bit          req;
    logic [31:0] addr;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one lookup, expected result pushed to the scoreboard
  task automatic lookup(logic [31:0] a, bit hit, logic [31:0] host, bit req, string tag);
    exp_t e;
    e.hit = hit; e.host = host; e.req = req; e.addr = a; e.tag = tag;
    @(posedge clk); #1;
    lk_valid = 1'b1; lk_addr = a;
    exp_q.push_back(e);
    @(posedge clk); #1;
    lk_valid = 1'b0;
  endtask

  task automatic install(logic [31:0] g, logic [31:0] h, bit with_snoop, logic [31:0] sa);
    @(posedge clk); #1;
    ins_valid = 1'b1; ins_guest = g; ins_host = h;
    snoop_valid = with_snoop; snoop_addr = sa;
    @(posedge clk); #1;
    ins_valid = 1'b0; snoop_valid = 1'b0;
  endtask

  task automatic page_write(logic [31:0] sa);
    @(posedge clk); #1;
    snoop_valid = 1'b1; snoop_addr = sa;
    @(posedge clk); #1;
    snoop_valid = 1'b0;
  endtask

  // monitor: compare each result against the scoreboard
  always @(negedge clk) begin
    if (rst_ni && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected result R2", {31'b0, res_valid}, 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(res_hit == e.hit, {e.tag, " hit"}, {63'b0, res_hit}, {63'b0, e.hit});
        check(res_host == e.host, {e.tag, " host"}, {32'b0, res_host}, {32'b0, e.host});
        check(xlate_req == e.req, {e.tag, " req"}, {63'b0, xlate_req}, {63'b0, e.req});
        if (e.req)
          check(xlate_addr == e.addr, {e.tag, " req addr"}, {32'b0, xlate_addr}, {32'b0, e.addr});
      end
    end else if (rst_ni && xlate_req) begin
      check(1'b0, "request without result R4", 64'd1, 64'd0);
    end
  end

  localparam logic [31:0] A = 32'h0001_0000, B = 32'h0001_0020, C = 32'h0002_0040;
  localparam logic [31:0] D = 32'h0002_0060, E = 32'h0003_0080, F = 32'h0004_0004;
  localparam logic [31:0] G1 = 32'h0006_0100, G2 = 32'h0007_0000;
  localparam logic [31:0] H = 32'h0008_0010, I = 32'h0009_0014;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!res_valid && !res_hit && !xlate_req && res_host == 0, "R1 in reset",
          {res_valid, res_hit, xlate_req}, 0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    @(negedge clk);
    check(!res_valid && !res_hit && !xlate_req && res_host == 0, "R1 after release",
          {res_valid, res_hit, xlate_req}, 0);

    // R3 R4: threshold 3
    lookup(A, 0, 0, 0, "R3 miss 1");
    lookup(A, 0, 0, 0, "R3 miss 2");
    lookup(A, 0, 0, 1, "R4 reach threshold");
    lookup(A, 0, 0, 0, "R4 held, no repeat");
    // R7 R2
    install(A, 32'h8000_1000, 0, 0);
    lookup(A, 1, 32'h8000_1000, 0, "R2 R7 hit");
    install(A, 32'h8000_2000, 0, 0);
    lookup(A, 1, 32'h8000_2000, 0, "R7 overwrite");
    // R8 R11
    lookup(B, 0, 0, 0, "R11 B miss 1");
    lookup(D, 0, 0, 0, "R9 D miss 1");
    install(B, 32'h8000_3000, 0, 0);
    install(C, 32'h8000_4000, 0, 0);
    install(D, 32'h8000_5000, 0, 0);
    lookup(B, 1, 32'h8000_3000, 0, "R11 B hit 1");
    lookup(B, 1, 32'h8000_3000, 0, "R11 B hit 2");
    lookup(B, 1, 32'h8000_3000, 0, "R11 B hit 3");
    lookup(A, 1, 32'h8000_2000, 0, "R8 refresh A");
    lookup(C, 1, 32'h8000_4000, 0, "R8 refresh C");
    lookup(D, 1, 32'h8000_5000, 0, "R8 refresh D");
    install(E, 32'h8000_6000, 0, 0);
    lookup(B, 0, 0, 0, "R8 R11 B evicted, count 2");
    lookup(B, 0, 0, 1, "R11 B reaches threshold");
    lookup(A, 1, 32'h8000_2000, 0, "R8 A kept");
    lookup(C, 1, 32'h8000_4000, 0, "R8 C kept");
    lookup(D, 1, 32'h8000_5000, 0, "R8 D kept");
    lookup(E, 1, 32'h8000_6000, 0, "R8 E installed");
    // R9
    page_write(32'h0002_0123);
    lookup(C, 0, 0, 0, "R9 C flushed");
    lookup(A, 1, 32'h8000_2000, 0, "R9 other page kept");
    lookup(E, 1, 32'h8000_6000, 0, "R9 other page kept E");
    lookup(D, 0, 0, 0, "R9 D flushed, count 1");
    lookup(D, 0, 0, 0, "R9 D count 2");
    lookup(D, 0, 0, 1, "R9 D count 3");
    // R10
    install(F, 32'h8000_7000, 1, 32'h0005_0000);
    lookup(F, 0, 0, 0, "R10 install dropped");
    install(F, 32'h8000_7000, 0, 0);
    lookup(F, 1, 32'h8000_7000, 0, "R10 later install");
    // R6: threshold 2, slot 0 aliasing
    threshold = 8'd2;
    lookup(G1, 0, 0, 0, "R6 G1 count 1");
    lookup(G2, 0, 0, 0, "R6 G2 replaces slot");
    lookup(G1, 0, 0, 0, "R6 G1 restarts");
    lookup(G1, 0, 0, 1, "R6 G1 reaches 2");
    // R5
    threshold = 8'd1;
    lookup(H, 0, 0, 1, "R5 threshold 1");
    threshold = 8'd0;
    lookup(I, 0, 0, 0, "R5 threshold 0 a");
    lookup(I, 0, 0, 0, "R5 threshold 0 b");
    lookup(I, 0, 0, 0, "R5 threshold 0 c");

    repeat (3) @(posedge clk);
    check(exp_q.size() == 0, "R2 results drained", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R2: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule